// File: doc/BRIEF.md
# Block Transfer DMA Engine

A single-channel engine that moves a block of words between one peripheral and memory without the processor handling each word. Software loads a start address, a word count and a control word through a small write-only register port. Setting the start bit in the control word begins a run. The engine then moves one word in every cycle in which the peripheral requests service and the bus is available. On each such cycle it issues a single-cycle memory read or write and acknowledges the peripheral in that same cycle.

The engine can share the bus in three ways. In burst mode it holds the bus until the whole block has moved. In cycle-stealing mode it gives the bus back after every word. In idle-slot mode it never asks for the bus and moves a word only while the processor reports that it is idle.

The run ends when the remaining count reaches zero. This sets a sticky done flag and, if enabled, an interrupt. Both stay set until software clears them.

Top module: `blkxfer_dma`

## Requirements
- R1: While reset is held, and in the first cycle after it, busReq, devAck, memRd, memWr, busy, done and irq are all low.
- R2: A start copies the base register into the current address. Each moved word uses the current address on memAddr. After each word the address steps by +1, or by -1 when control bit 3 is set, wrapping modulo 2^ADDR_W.
- R3: The 16-bit remaining count is loaded from the count register at start and drops by one per moved word. In the cycle after the last word, busy is low and done is high.
- R4: Control bit 0 selects the direction. With 0 (memory to device) each word asserts memRd and drives devWrData from memRdData. With 1 (device to memory) each word asserts memWr and drives memWrData from devRdData. The two strobes are never high together.
- R5: A word moves, with devAck and the memory strobe in the same cycle, exactly when devReq is high and the bus is available. In burst and cycle-stealing modes the bus is available when busReq and busGrant are both high; in idle-slot mode it is available when cpuIdle is high. In every other cycle devAck, memRd and memWr are low.
- R6: Control bits 2:1 select the mode: 00 or 11 burst, 01 cycle-stealing, 10 idle-slot. In burst mode busReq is high in every cycle from the one after start until the last word.
- R7: In cycle-stealing mode busReq is low in the cycle after every moved word, and is raised again in the cycle after that if words remain.
- R8: In idle-slot mode busReq is never asserted.
- R9: On completion irq is raised only if control bit 4 was set.
- R10: done and irq stay set until a write to register select 3 with bit 0 high. A write to select 3 with bit 0 low leaves them unchanged.
- R11: Writes to select 0 (base), 1 (count) and 2 (control; bit 5 is start) are ignored while busy. A later start uses the values loaded before the run.
- R12: A start with a loaded count of zero moves no words, asserts no bus request and sets done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base, 1 count, 2 control, 3 status clear |
| regWdata | input | REG_W | Register write data |
| busReq | output | 1 | Bus request to the processor |
| busGrant | input | 1 | Bus grant from the processor |
| cpuIdle | input | 1 | Processor idle indication, used in idle-slot mode |
| devReq | input | 1 | Peripheral service request |
| devAck | output | 1 | Peripheral acknowledge, high in the cycle a word moves |
| devRdData | input | DATA_W | Word offered by the peripheral |
| devWrData | output | DATA_W | Word delivered to the peripheral |
| memAddr | output | ADDR_W | Memory address of the current word |
| memRd | output | 1 | Single-cycle memory read strobe |
| memWr | output | 1 | Single-cycle memory write strobe |
| memWrData | output | DATA_W | Memory write data |
| memRdData | input | DATA_W | Memory read data, valid in the same cycle as memRd |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Sticky completion interrupt |

## Verification
On every cycle, the assertions check several rules:
- a word moves only under a peripheral request and while the bus is held;
- cycle-stealing drops the request after each word, and burst keeps it;
- idle-slot mode never requests the bus;
- the count and the address step once per word;
- the loaded registers stay frozen while a run is active;
- done is sticky;
- irq rises only when enabled;
- a zero count finishes at once.

Other properties can only be shown by the bench's scenarios, which compare against its own address and count model under random grant, request and idle patterns:
- the exact address sequence, including wrap-around when decrementing;
- the data passing through in each direction;
- the start of a later run from the pre-run parameters after writes were ignored;
- the done and irq levels seen at the ports.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    MODE_BURST     = 2'd0,
    MODE_STEAL     = 2'd1,
    MODE_SNOOP     = 2'd2,
    MODE_BURST_ALT = 2'd3
  } xferMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUS   = 2'd1,
    ST_GAP   = 2'd2,
    ST_SNOOP = 2'd3
  } ctrlState_e;

  typedef struct packed {
    logic      irqEn;
    logic      decr;
    xferMode_e mode;
    logic      devToMem;
  } xferCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRun;
    logic stepWord;
  } ctrlStrobe_t;

  localparam logic [1:0] SEL_BASE   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

  localparam int CB_DIR   = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_DECR  = 3;
  localparam int CB_IRQEN = 4;
  localparam int CB_START = 5;
  localparam int SB_CLEAR = 0;

endpackage

// File: rtl/blkxfer_dpath.sv
module blkxfer_dpath
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              busy,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] devRdData,
  input  logic [DATA_W-1:0] memRdData,
  output xferCfg_t          cfg,
  output xferCfg_t          startCfg,
  output logic              startHit,
  output logic              clrHit,
  output logic              loadIsZero,
  output logic              lastWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] devWrData,
  output logic              devAck
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] baseReg;
  logic [CNT_W-1:0]  cntReg;
  xferCfg_t          cfgReg;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  wordsLeft;
  logic              wrOpen;

  // a write is accepted only when no run is active
  assign wrOpen = regWe && !busy;

  always_comb begin
    startCfg.devToMem = regWdata[CB_DIR];
    startCfg.mode     = xferMode_e'(regWdata[CB_MODE +: 2]);
    startCfg.decr     = regWdata[CB_DECR];
    startCfg.irqEn    = regWdata[CB_IRQEN];
  end

  assign startHit   = wrOpen && (regSel == SEL_CTRL) && regWdata[CB_START];
  assign clrHit     = regWe && (regSel == SEL_STATUS) && regWdata[SB_CLEAR];
  assign loadIsZero = (cntReg == '0);
  assign lastWord   = (wordsLeft == CNT_ONE);
  assign cfg        = cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      cntReg  <= '0;
      cfgReg  <= '0;
    end else if (wrOpen) begin
      case (regSel)
        SEL_BASE:  baseReg <= ADDR_W'(regWdata);
        SEL_COUNT: cntReg  <= CNT_W'(regWdata);
        SEL_CTRL:  cfgReg  <= startCfg;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      wordsLeft <= '0;
    end else if (strobe.loadRun) begin
      curAddr   <= baseReg;
      wordsLeft <= cntReg;
    end else if (strobe.stepWord) begin
      curAddr   <= cfgReg.decr ? curAddr - ADDR_ONE : curAddr + ADDR_ONE;
      wordsLeft <= wordsLeft - CNT_ONE;
    end
  end

  assign memAddr   = curAddr;
  assign devAck    = strobe.stepWord;
  assign memRd     = strobe.stepWord && !cfgReg.devToMem;
  assign memWr     = strobe.stepWord && cfgReg.devToMem;
  assign memWrData = devRdData;
  assign devWrData = memRdData;

  // count falls by one per word (R3)
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepWord |=> wordsLeft == $past(wordsLeft) - CNT_ONE);

  // address steps by one in the configured sense (R2)
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepWord |=> curAddr == ($past(cfgReg.decr) ? $past(curAddr) - ADDR_ONE
                                                       : $past(curAddr) + ADDR_ONE));

  // loaded parameters frozen during a run (R11)
  p_frozen_regs_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(baseReg) && $stable(cntReg) && $stable(cfgReg));

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  xferMode_e   runMode,
  input  logic        runIrqEn,
  input  xferMode_e   startMode,
  input  logic        startIrqEn,
  input  logic        startHit,
  input  logic        clrHit,
  input  logic        loadIsZero,
  input  logic        lastWord,
  input  logic        busGrant,
  input  logic        cpuIdle,
  input  logic        devReq,
  output ctrlStrobe_t strobe,
  output logic        busReq,
  output logic        busy,
  output logic        done,
  output logic        irq
);

  ctrlState_e state, stateNext;
  logic step;
  logic finish;
  logic emptyStart;
  logic setFlags;
  logic setIrq;

  assign busReq = (state == ST_BUS);
  assign busy   = (state != ST_IDLE);

  assign step = devReq && (((state == ST_BUS) && busGrant) ||
                           ((state == ST_SNOOP) && cpuIdle));
  assign finish     = step && lastWord;
  assign emptyStart = startHit && loadIsZero;
  assign setFlags   = finish || emptyStart;
  assign setIrq     = (finish && runIrqEn) || (emptyStart && startIrqEn);

  assign strobe.loadRun  = startHit;
  assign strobe.stepWord = step;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startHit && !loadIsZero)
          stateNext = (startMode == MODE_SNOOP) ? ST_SNOOP : ST_BUS;
      end
      ST_BUS: begin
        if (step) begin
          if (lastWord)                      stateNext = ST_IDLE;
          else if (runMode == MODE_STEAL)    stateNext = ST_GAP;
          else                               stateNext = ST_BUS;
        end
      end
      ST_GAP:   stateNext = ST_BUS;
      ST_SNOOP: if (finish) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (setFlags)    done <= 1'b1;
      else if (clrHit) done <= 1'b0;
      if (setIrq)      irq  <= 1'b1;
      else if (clrHit) irq  <= 1'b0;
    end
  end

  // word only under peripheral request (R5)
  p_ack_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepWord |-> devReq);

  // bus modes move words only while owning the bus (R5)
  p_bus_owned_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepWord && runMode != MODE_SNOOP) |-> (busReq && busGrant));

  // idle-slot mode never requests (R8)
  p_snoop_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == MODE_SNOOP) |-> !busReq);

  // cycle stealing releases after each word (R7)
  p_steal_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepWord && runMode == MODE_STEAL) |=> !busReq);

  // burst keeps the bus until the last word (R6)
  p_burst_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && (runMode == MODE_BURST || runMode == MODE_BURST_ALT)
     && !(strobe.stepWord && lastWord)) |=> busReq);

  // done sticky until cleared (R10)
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !clrHit) |=> done);

  // interrupt only when enabled (R9)
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> runIrqEn);

  // empty run completes at once (R12)
  p_zero_count_r12: assert property (@(posedge clk) disable iff (!rstN)
    (startHit && loadIsZero) |=> (done && !busy));

endmodule

// File: rtl/blkxfer_dma.sv
module blkxfer_dma
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  output logic              busReq,
  input  logic              busGrant,
  input  logic              cpuIdle,
  input  logic              devReq,
  output logic              devAck,
  input  logic [DATA_W-1:0] devRdData,
  output logic [DATA_W-1:0] devWrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic              done,
  output logic              irq
);

  ctrlStrobe_t strobe;
  xferCfg_t    cfg;
  xferCfg_t    startCfg;
  logic        startHit;
  logic        clrHit;
  logic        loadIsZero;
  logic        lastWord;

  blkxfer_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .busy       (busy),
    .strobe     (strobe),
    .devRdData  (devRdData),
    .memRdData  (memRdData),
    .cfg        (cfg),
    .startCfg   (startCfg),
    .startHit   (startHit),
    .clrHit     (clrHit),
    .loadIsZero (loadIsZero),
    .lastWord   (lastWord),
    .memAddr    (memAddr),
    .memRd      (memRd),
    .memWr      (memWr),
    .memWrData  (memWrData),
    .devWrData  (devWrData),
    .devAck     (devAck)
  );

  blkxfer_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .runMode    (cfg.mode),
    .runIrqEn   (cfg.irqEn),
    .startMode  (startCfg.mode),
    .startIrqEn (startCfg.irqEn),
    .startHit   (startHit),
    .clrHit     (clrHit),
    .loadIsZero (loadIsZero),
    .lastWord   (lastWord),
    .busGrant   (busGrant),
    .cpuIdle    (cpuIdle),
    .devReq     (devReq),
    .strobe     (strobe),
    .busReq     (busReq),
    .busy       (busy),
    .done       (done),
    .irq        (irq)
  );

  // read and write strobes exclusive (R4)
  p_one_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

endmodule

// File: tb/blkxfer_dma_tb_top.sv
module blkxfer_dma_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [DW-1:0] MEM_KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          regWe = 1'b0;
  logic [1:0]    regSel = '0;
  logic [15:0]   regWdata = '0;
  logic          busGrant = 1'b0;
  logic          cpuIdle = 1'b0;
  logic          devReq = 1'b0;
  logic [DW-1:0] devRdData = '0;
  logic [DW-1:0] memRdData;
  logic          busReq, devAck, memRd, memWr, busy, done, irq;
  logic [DW-1:0] devWrData, memWrData;
  logic [AW-1:0] memAddr;

  assign memRdData = memAddr ^ MEM_KEY;

  blkxfer_dma dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busReq(busReq), .busGrant(busGrant), .cpuIdle(cpuIdle), .devReq(devReq),
    .devAck(devAck), .devRdData(devRdData), .devWrData(devWrData),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWrData(memWrData),
    .memRdData(memRdData), .busy(busy), .done(done), .irq(irq)
  );

  int  nCmp = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  function automatic logic [15:0] ctrlWord(input bit dir, input logic [1:0] mode,
                                            input bit decr, input bit irqEn);
    return {10'b0, 1'b1, irqEn, decr, mode, dir};
  endfunction

  // one complete run with per-cycle checks
  task automatic runXfer(input logic [AW-1:0] base, input logic [15:0] count,
                         input bit dir, input logic [1:0] mode, input bit decr,
                         input bit irqEn, input bit midWrite, input bit skipLoad);
    logic [AW-1:0] expAddr;
    int left;
    int cyc;
    bit prevAck;
    bit expStep;
    if (!skipLoad) begin
      regWrite(2'd0, base);
      regWrite(2'd1, count);
    end
    regWrite(2'd2, ctrlWord(dir, mode, decr, irqEn));
    if (count == 0) begin
      devReq = 1'b1; busGrant = 1'b1; cpuIdle = 1'b1;
      #1;
      check(!busy && done, "R12", "busy/done after empty start", {busy, done}, 2'b01);
      for (int k = 0; k < 3; k++) begin
        check(!busReq && !devAck && !memRd && !memWr, "R12", "no bus activity",
              {busReq, devAck, memRd, memWr}, 0);
        @(negedge clk);
        #1;
      end
      devReq = 1'b0;
    end else begin
      expAddr = base; left = count; cyc = 0; prevAck = 1'b0;
      while (left > 0 && cyc < 5000) begin
        devReq    = ($urandom_range(0, 3) != 0);
        busGrant  = ($urandom_range(0, 3) != 0);
        cpuIdle   = $urandom_range(0, 1) != 0;
        devRdData = DW'($urandom);
        regWe     = 1'b0;
        if (midWrite && cyc == 2) begin
          regWe = 1'b1; regSel = 2'd0; regWdata = ~base;
        end else if (midWrite && cyc == 3) begin
          regWe = 1'b1; regSel = 2'd1; regWdata = 16'd2;
        end else if (midWrite && cyc == 4) begin
          regWe = 1'b1; regSel = 2'd2; regWdata = ctrlWord(!dir, 2'd2, !decr, 1'b0);
        end
        #1;
        check(busy, "R3", "busy during run", busy, 1);
        if (mode == 2'd0 || mode == 2'd3)
          check(busReq, "R6", "burst holds request", busReq, 1);
        else if (mode == 2'd1 && prevAck)
          check(!busReq, "R7", "steal releases after word", busReq, 0);
        else if (mode == 2'd2)
          check(!busReq, "R8", "idle-slot never requests", busReq, 0);
        expStep = devReq && ((mode == 2'd2) ? cpuIdle : (busReq && busGrant));
        check(devAck == expStep, "R5", "word move condition", devAck, expStep);
        if (devAck) begin
          check(memAddr == expAddr, "R2", "word address", memAddr, expAddr);
          if (dir) begin
            check(memWr && !memRd, "R4", "dev-to-mem strobes", {memRd, memWr}, 2'b01);
            check(memWrData == devRdData, "R4", "mem write data", memWrData, devRdData);
          end else begin
            check(memRd && !memWr, "R4", "mem-to-dev strobes", {memRd, memWr}, 2'b10);
            check(devWrData == (expAddr ^ MEM_KEY), "R4", "device write data",
                  devWrData, expAddr ^ MEM_KEY);
          end
          expAddr = decr ? expAddr - 1'b1 : expAddr + 1'b1;
          left--;
        end else begin
          check(!memRd && !memWr, "R5", "no memory strobe without word",
                {memRd, memWr}, 0);
        end
        prevAck = devAck;
        cyc++;
        @(negedge clk);
      end
      regWe = 1'b0; devReq = 1'b0;
      #1;
      check(!busy && done, "R3", "terminal count ends run", {busy, done}, 2'b01);
      check(irq == irqEn, "R9", "interrupt enable gating", irq, irqEn);
      check(!busReq, "R3", "request dropped after run", busReq, 0);
    end
    repeat (3) @(negedge clk);
    #1;
    check(done && irq == irqEn, "R10", "flags persist", {done, irq}, {1'b1, irqEn});
    regWrite(2'd3, 16'h0000);
    #1;
    check(done && irq == irqEn, "R10", "clear bit low keeps flags", {done, irq},
          {1'b1, irqEn});
    regWrite(2'd3, 16'h0001);
    #1;
    check(!done && !irq, "R10", "clear drops flags", {done, irq}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    check({busReq, devAck, memRd, memWr, busy, done, irq} == 0, "R1",
          "outputs in reset", {busReq, devAck, memRd, memWr, busy, done, irq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check({busReq, devAck, memRd, memWr, busy, done, irq} == 0, "R1",
          "outputs after reset", {busReq, devAck, memRd, memWr, busy, done, irq}, 0);

    // directed corners
    runXfer(16'h1234, 16'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);  // R12
    runXfer(16'h0000, 16'd3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);  // R2 wrap
    runXfer(16'hFFFE, 16'd4, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);  // R2 up wrap
    runXfer(16'h0040, 16'd1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);  // R7 single
    runXfer(16'h2000, 16'd12, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0); // R11 writes
    runXfer(16'h2000, 16'd12, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1); // R11 reuse
    runXfer(16'h3000, 16'd10, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0); // R8

    for (int t = 0; t < 24; t++) begin
      runXfer(AW'($urandom), 16'($urandom_range(1, 40)), $urandom_range(0, 1) != 0,
              2'($urandom_range(0, 3)), $urandom_range(0, 1) != 0,
              $urandom_range(0, 1) != 0, 1'b0, 1'b0);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule